// File: doc/BRIEF.md
# Line-Rate PLL State Serializer

This block sends a short serial frame once per video line so that a downstream circuit can follow the state of the timing-recovery loops. Each frame carries three items. The first is the low part of the horizontal line-locked loop increment. The second is the subcarrier oscillator increment without its always-zero top bit. The third is a flag that is pulled low for one frame after a subcarrier phase reset has been requested. A start marker, a sequence bit and a set of zero-filled spare slots complete the frame.

A line-start strobe triggers a frame. On that strobe the block copies both increment words into shadow registers. It then steps through 69 time slots, each lasting four cycles of the line-locked clock, and drives one bit per slot on a single output. Outside a frame the output stays low. A line-start strobe that arrives while a frame is still running is dropped. A phase-reset request is held until the start of the next frame; that frame carries the cleared flag and consumes the request.

Top module: `ltx_serializer`

## Requirements
- R1: While the synchronous active-high reset is asserted, and from the first cycle after it, serOut is 0. The reset also discards any pending phase-reset request and returns the sequence bit to 0.
- R2: While no frame is running, serOut is 0.
- R3: On a clock edge where lineStart is 1 and no frame is running, a frame begins. Slot k, for k from 0 to 68, is driven during the four cycles that start 4k+1 cycles after that edge. The frame then ends and serOut returns to 0.
- R4: Slot 0 carries 0 and slot 1 carries 1.
- R5: Slots 2 to 17 carry bits 15 down to 0 of hIncr as captured at the frame's start edge. Bit 15 is in slot 2.
- R6: Slots 19 to 41 carry bits 22 down to 0 of scIncr as captured at the frame's start edge. Bit 22 is in slot 19.
- R7: Slot 67 carries 1. It carries 0 in the first frame whose start edge comes strictly after a phaseResetReq pulse. A request sampled on the start edge itself applies to the following frame. The request is used up by that one frame.
- R8: Slot 63 carries a sequence bit. It is 0 in the first frame after reset and toggles from each frame to the next.
- R9: Slots 18, 42 to 62, 64 to 66 and 68 carry 0.
- R10: Changes to hIncr and scIncr after the start edge do not alter the frame in progress.
- R11: A lineStart pulse during a running frame is dropped. It neither restarts the current frame nor starts a later one.
- R12: A reset applied in the middle of a frame stops it: serOut is 0 from the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked system clock |
| rst | input | 1 | Synchronous active-high reset |
| lineStart | input | 1 | One-cycle strobe that starts a frame |
| hIncr | input | HINC_W (20) | Horizontal loop increment; only the low HINC_TX bits are sent |
| scIncr | input | SC_W (24) | Subcarrier oscillator increment; only the low SC_TX bits are sent |
| phaseResetReq | input | 1 | One-cycle request for a subcarrier phase reset |
| serOut | output | 1 | Serial frame output |

## Verification
The assertions assume that lineStart and phaseResetReq are synchronous to clk and that reset is held for at least one edge. They do not assume anything about pulse spacing, because overlapping strobes are legal and must be dropped. The stimulus changes every input only on falling edges. It keeps strobes and requests one cycle wide, and it sends an overlapping strobe and a request at the start edge on purpose so that the drop and carry-over rules are exercised. The upper bits of hIncr are always driven as 0100b and the top bit of scIncr as 0. This matches the input assumption: those bits are never sent.

// File: rtl/ltx_pkg.sv
`timescale 1ns/1ps
package ltx_pkg;
  localparam int SLOT_W    = 7;
  localparam int SLOT_LO   = 0;
  localparam int SLOT_HI   = 1;
  localparam int SLOT_H0   = 2;
  localparam int SLOT_SC0  = 19;
  localparam int SLOT_SEQ  = 63;
  localparam int SLOT_FLAG = 67;
  localparam int SLOT_LAST = 68;

  typedef struct packed {
    logic              capture;
    logic              busy;
    logic [SLOT_W-1:0] slot;
  } ltx_strobe_t;
endpackage

// File: rtl/ltx_ctrl.sv
`timescale 1ns/1ps
module ltx_ctrl
  import ltx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lineStart,
  output ltx_strobe_t st
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [SLOT_W-1:0] slot;
  logic              busy;
  logic              slotTick;
  logic              capture;

  assign slotTick = (divCnt == DIV_W'(CLK_DIV - 1));
  assign capture  = lineStart && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      slot   <= '0;
      divCnt <= '0;
    end else if (capture) begin
      busy   <= 1'b1;
      slot   <= '0;
      divCnt <= '0;
    end else if (busy) begin
      if (slotTick) begin
        divCnt <= '0;
        if (slot == SLOT_W'(SLOT_LAST)) begin
          busy <= 1'b0;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st.capture = capture;
    st.busy    = busy;
    st.slot    = slot;
  end

  // R3: the slot index never leaves the frame map
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot <= SLOT_W'(SLOT_LAST));

  // R3: within a frame the slot either holds or moves up by one
  a_r3_slot_step: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || slot == $past(slot) || slot == $past(slot) + 1'b1));

  // R11: a strobe during a running frame does not restart it
  a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && lineStart && slot != '0 && slot != SLOT_W'(SLOT_LAST))
      |=> (busy && slot != '0));
endmodule

// File: rtl/ltx_datapath.sv
`timescale 1ns/1ps
module ltx_datapath
  import ltx_pkg::*;
#(
  parameter int HINC_W  = 20,
  parameter int HINC_TX = 16,
  parameter int SC_W    = 24,
  parameter int SC_TX   = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  ltx_strobe_t       st,
  input  logic [HINC_W-1:0] hIncr,
  input  logic [SC_W-1:0]   scIncr,
  input  logic              phaseResetReq,
  output logic              serOut
);
  localparam int HIDX_W = $clog2(HINC_TX);
  localparam int SIDX_W = $clog2(SC_TX);
  localparam int H_END  = SLOT_H0 + HINC_TX - 1;
  localparam int SC_END = SLOT_SC0 + SC_TX - 1;

  logic [HINC_TX-1:0] hShadow;
  logic [SC_TX-1:0]   scShadow;
  logic               pending;
  logic               frameFlag;
  logic               frameSeq;
  logic               seqState;
  logic [HIDX_W-1:0]  hIdx;
  logic [SIDX_W-1:0]  scIdx;
  logic               unusedBits;

  assign unusedBits = ^{hIncr[HINC_W-1:HINC_TX], scIncr[SC_W-1:SC_TX]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hShadow   <= '0;
      scShadow  <= '0;
      pending   <= 1'b0;
      frameFlag <= 1'b1;
      frameSeq  <= 1'b0;
      seqState  <= 1'b0;
    end else begin
      pending <= phaseResetReq || (pending && !st.capture);
      if (st.capture) begin
        hShadow   <= hIncr[HINC_TX-1:0];
        scShadow  <= scIncr[SC_TX-1:0];
        frameFlag <= !pending;
        frameSeq  <= seqState;
        seqState  <= !seqState;
      end
    end
  end

  always_comb begin
    int s;
    s      = int'(st.slot);
    hIdx   = HIDX_W'(HINC_TX - 1 - (s - SLOT_H0));
    scIdx  = SIDX_W'(SC_TX - 1 - (s - SLOT_SC0));
    serOut = 1'b0;
    if (st.busy) begin
      if (s == SLOT_HI)                        serOut = 1'b1;
      else if (s >= SLOT_H0 && s <= H_END)     serOut = hShadow[hIdx];
      else if (s >= SLOT_SC0 && s <= SC_END)   serOut = scShadow[scIdx];
      else if (s == SLOT_SEQ)                  serOut = frameSeq;
      else if (s == SLOT_FLAG)                 serOut = frameFlag;
    end
  end

  // R10: captured words stay fixed while a frame runs
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    st.busy |=> ($stable(hShadow) && $stable(scShadow)));

  // R7: a frame start consumes an earlier request
  a_r7_pending_consumed: assert property (@(posedge clk) disable iff (rst)
    (st.capture && !phaseResetReq) |=> !pending);

  // R7: a request always leaves something pending
  a_r7_request_held: assert property (@(posedge clk) disable iff (rst)
    phaseResetReq |=> pending);

  // R1: reset discards a pending request
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> !pending);
endmodule

// File: rtl/ltx_serializer.sv
`timescale 1ns/1ps
module ltx_serializer
  import ltx_pkg::*;
#(
  parameter int HINC_W  = 20,
  parameter int HINC_TX = 16,
  parameter int SC_W    = 24,
  parameter int SC_TX   = 23,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineStart,
  input  logic [HINC_W-1:0] hIncr,
  input  logic [SC_W-1:0]   scIncr,
  input  logic              phaseResetReq,
  output logic              serOut
);
  ltx_strobe_t st;

  ltx_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .lineStart (lineStart),
    .st        (st)
  );

  ltx_datapath #(
    .HINC_W (HINC_W),
    .HINC_TX(HINC_TX),
    .SC_W   (SC_W),
    .SC_TX  (SC_TX)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .st           (st),
    .hIncr        (hIncr),
    .scIncr       (scIncr),
    .phaseResetReq(phaseResetReq),
    .serOut       (serOut)
  );

  // R1 / R12: the output is quiet in the cycle after any reset edge
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> !serOut);

  // R2: a frame never begins without a strobe
  a_r2_no_spontaneous: assert property (@(posedge clk) disable iff (rst)
    (!st.busy && !lineStart) |=> !st.busy);
endmodule

// File: tb/ltx_serializer_tb.sv
`timescale 1ns/1ps
module ltx_serializer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineStart = 1'b0;
  logic [19:0] hIncr = '0;
  logic [23:0] scIncr = '0;
  logic        phaseResetReq = 1'b0;
  logic        serOut;

  int  checks = 0;
  int  failures = 0;
  bit  tbPending = 0;
  bit  tbSeq = 0;
  bit  finished = 0;

  typedef struct { bit exp; int slot; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  ltx_serializer u_dut (
    .clk(clk), .rst(rst), .lineStart(lineStart), .hIncr(hIncr),
    .scIncr(scIncr), .phaseResetReq(phaseResetReq), .serOut(serOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit expBit(int s, logic [15:0] h, logic [22:0] sc, bit seq, bit flag);
    if (s == 1) return 1'b1;
    if (s >= 2 && s <= 17) return h[17 - s];
    if (s >= 19 && s <= 41) return sc[41 - s];
    if (s == 63) return seq;
    if (s == 67) return flag;
    return 1'b0;
  endfunction

  function automatic string reqOf(int s);
    if (s <= 1) return "R4";
    if (s >= 2 && s <= 17) return "R5";
    if (s >= 19 && s <= 41) return "R6";
    if (s == 63) return "R8";
    if (s == 67) return "R7";
    return "R9";
  endfunction

  // monitor: one expected item per cycle, sampled mid-cycle (R3 timing)
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(serOut == it.exp, $sformatf("%s/R3 slot %0d", reqOf(it.slot), it.slot),
            int'(serOut), int'(it.exp));
    end
  end

  task automatic startFrame(input logic [19:0] h, input logic [23:0] sc, input bit reqSame);
    bit flag;
    @(negedge clk);
    hIncr = h; scIncr = sc; lineStart = 1'b1; phaseResetReq = reqSame;
    @(posedge clk); #1;
    flag = !tbPending;
    tbPending = reqSame;
    for (int s = 0; s <= 68; s++)
      for (int c = 0; c < 4; c++)
        q.push_back('{expBit(s, h[15:0], sc[22:0], tbSeq, flag), s});
    tbSeq = !tbSeq;
    @(negedge clk);
    lineStart = 1'b0; phaseResetReq = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); phaseResetReq = 1'b1; tbPending = 1;
    @(negedge clk); phaseResetReq = 1'b0;
  endtask

  task automatic waitDone();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic checkIdle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(serOut == 1'b0, tag, int'(serOut), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: output low during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(serOut == 1'b0, "R1 reset", int'(serOut), 0);
    end
    rst = 1'b0;
    checkIdle(6, "R2 idle");

    // several data patterns (R4 R5 R6 R8 R9)
    startFrame(20'h4A5C3, 24'h5B1E97, 0); waitDone(); checkIdle(3, "R2 after frame");
    startFrame(20'h40000, 24'h7FFFFF, 0); waitDone(); checkIdle(3, "R2 after frame");
    startFrame(20'h4FFFF, 24'h000000, 0); waitDone();

    // R7: request while idle -> next frame flag 0, then back to 1
    pulseReq();
    startFrame(20'h41234, 24'h2AAAAA, 0); waitDone();
    startFrame(20'h4F0F0, 24'h555555, 0); waitDone();

    // R10, R11, R7: changes, stray strobe and request inside a frame
    startFrame(20'h4C3A5, 24'h13579B, 0);
    repeat (100) @(negedge clk);
    hIncr = 20'h4FFFF; scIncr = 24'h7FFFFF;   // R10
    pulseReq();                              // R7 during frame
    @(negedge clk); lineStart = 1'b1;        // R11 stray strobe
    @(negedge clk); lineStart = 1'b0;
    waitDone();
    checkIdle(12, "R11 strobe dropped");
    startFrame(20'h40F0F, 24'h0F0F0F, 0); waitDone();   // flag 0

    // R7: request on the start edge belongs to the next frame
    startFrame(20'h4ABCD, 24'h6DB6DB, 1); waitDone();   // flag 1
    startFrame(20'h48421, 24'h124924, 0); waitDone();   // flag 0

    // R12 / R1: reset in mid-frame with a request pending
    startFrame(20'h47777, 24'h333333, 0);
    repeat (50) @(negedge clk);
    pulseReq();
    @(posedge clk); #1;
    q.delete(); rst = 1'b1; tbPending = 0; tbSeq = 0;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(serOut == 1'b0, "R12 mid-frame reset", int'(serOut), 0);
    end
    rst = 1'b0;
    checkIdle(6, "R12 stays idle");
    startFrame(20'h4E1E1, 24'h1E1E1E, 0); waitDone();   // flag 1, seq 0 (R1 R8)
    checkIdle(4, "R2 final idle");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule